// File: doc/BRIEF.md
# Multi-mode stepper motor sequencer

This block produces the four coil drive levels of a stepper motor. Its core is a three-bit phase counter that moves through eight positions. It advances by one position on each clock edge while the step enable is high, and the direction input sets whether it counts up or down. A two-bit mode input chooses how the phase becomes coil levels. The choices are single-coil wave drive, two-coil full step, and half step, which alternates between one coil and two coils. A fourth choice ignores the phase and copies a four-bit control word to the coils. This lets firmware drive the coils directly.

Step timing comes from outside: the enable is pulsed once per motor step by a rate generator. The coil outputs are registered. They show the position reached at an edge, decoded with the mode and control word applied at that edge. Power stages and current control sit downstream.

Top module: `stepper_seq`

## Requirements
- R1: With `step_en_i` high at a clock edge, the phase moves by one. It goes up when `dir_i` is 1 and down when `dir_i` is 0, and wraps from 7 to 0 and from 0 to 7.
- R2: With `step_en_i` low at a clock edge, the phase holds its value.
- R3: Mode 0 (wave) drives coil pattern 0001, 0010, 0100, 1000 for phases 0 to 3 and again for phases 4 to 7. Exactly one coil is on, so each step turns one coil off as the next turns on.
- R4: Mode 1 (full step) drives 0011, 0110, 1100, 1001 for phases 0 to 3 and again for phases 4 to 7.
- R5: Mode 2 (half step) drives 0001, 0011, 0010, 0110, 0100, 1100, 1000, 1001 for phases 0 to 7.
- R6: Mode 3 (direct) copies `ctrl_i` to `coil_o` at each edge. The phase still follows R1 and R2, so a later decoded mode resumes from the updated phase.
- R7: `coil_o` is registered. A change of mode, control word or phase is seen only after the next clock edge, and that edge's step is already reflected in the decoded pattern.
- R8: While `rst_ni` is low, the phase is 0 and `coil_o` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_en_i | input | 1 | Advance the phase at this edge |
| dir_i | input | 1 | 1 counts up, 0 counts down |
| mode_i | input | 2 | 0 wave, 1 full step, 2 half step, 3 direct |
| ctrl_i | input | 4 | Coil levels used in direct mode |
| coil_o | output | 4 | Registered coil drive levels, bit n is coil n |

## Verification
The bench walks past the 7-to-0 wrap upward and the 0-to-7 wrap downward in several modes. A counter with a wrong wrap, or with inverted direction, shows up as a misplaced pattern. Idle cycles with the enable low would expose a phase that drifts. The bench steps while in direct mode and then returns to half step, so a counter frozen in direct mode produces a stale pattern. A mode change without a step is sampled both before and after the edge. This catches an unregistered output, and also a decode that lags the phase by one cycle.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  localparam int unsigned COIL_N = 4;

  typedef enum logic [1:0] {
    MODE_WAVE   = 2'd0,
    MODE_FULL   = 2'd1,
    MODE_HALF   = 2'd2,
    MODE_DIRECT = 2'd3
  } drive_mode_e;
endpackage

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int unsigned PHASE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_en_i,
  input  logic               dir_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [PHASE_W-1:0] phase_next_o
);
  logic [PHASE_W-1:0] phase_q;

  // natural modulo wrap of PHASE_W bits
  always_comb begin
    phase_next_o = phase_q;
    if (step_en_i) begin
      phase_next_o = dir_i ? phase_q + PHASE_W'(1) : phase_q - PHASE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_next_o;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/coil_decoder.sv
module coil_decoder
  import stepper_pkg::*;
#(
  parameter int unsigned COILS   = 4,
  parameter int unsigned PHASE_W = $clog2(2 * COILS)
) (
  input  logic [PHASE_W-1:0] phase_i,
  input  drive_mode_e        mode_i,
  input  logic [COILS-1:0]   ctrl_i,
  output logic [COILS-1:0]   coil_o
);
  localparam int unsigned IDX_W = $clog2(COILS);

  logic [COILS-1:0] wave_pat, full_pat, half_base, half_pat;

  function automatic logic [COILS-1:0] rotl1(input logic [COILS-1:0] v);
    return {v[COILS-2:0], v[COILS-1]};
  endfunction

  always_comb begin
    wave_pat  = COILS'(1) << phase_i[IDX_W-1:0];
    full_pat  = wave_pat | rotl1(wave_pat);
    half_base = COILS'(1) << phase_i[PHASE_W-1:1];
    half_pat  = phase_i[0] ? (half_base | rotl1(half_base)) : half_base;
    unique case (mode_i)
      MODE_WAVE:   coil_o = wave_pat;
      MODE_FULL:   coil_o = full_pat;
      MODE_HALF:   coil_o = half_pat;
      MODE_DIRECT: coil_o = ctrl_i;
      default:     coil_o = '0;
    endcase
  end
endmodule

// File: rtl/stepper_seq.sv
module stepper_seq
  import stepper_pkg::*;
#(
  parameter int unsigned COILS = COIL_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_en_i,
  input  logic             dir_i,
  input  logic [1:0]       mode_i,
  input  logic [COILS-1:0] ctrl_i,
  output logic [COILS-1:0] coil_o
);
  localparam int unsigned PHASE_W = $clog2(2 * COILS);

  logic [PHASE_W-1:0] phase_q, phase_next;
  logic [COILS-1:0]   coil_d, coil_q;

  phase_counter #(.PHASE_W(PHASE_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .step_en_i    (step_en_i),
    .dir_i        (dir_i),
    .phase_o      (phase_q),
    .phase_next_o (phase_next)
  );

  // decode the next phase so the registered output matches the new position
  coil_decoder #(.COILS(COILS), .PHASE_W(PHASE_W)) u_dec (
    .phase_i (phase_next),
    .mode_i  (drive_mode_e'(mode_i)),
    .ctrl_i  (ctrl_i),
    .coil_o  (coil_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) coil_q <= '0;
    else         coil_q <= coil_d;
  end

  assign coil_o = coil_q;
endmodule

// File: rtl/stepper_seq_chk.sv
module stepper_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       step_en_i,
  input logic       dir_i,
  input logic [1:0] mode_i,
  input logic [3:0] ctrl_i,
  input logic [2:0] phase_i,
  input logic [3:0] coil_o
);
  a_r1_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && dir_i && phase_i == 3'd7) |=> phase_i == 3'd0);

  a_r1_wrap_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && !dir_i && phase_i == 3'd0) |=> phase_i == 3'd7);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_en_i |=> $stable(phase_i));

  a_r3_one_coil: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |=> $countones(coil_o) == 1);

  a_r4_two_coils: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1) |=> $countones(coil_o) == 2);

  a_r5_half_coils: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |=> ($countones(coil_o) == 1 || $countones(coil_o) == 2));

  a_r6_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |=> coil_o == $past(ctrl_i));

  always_comb begin
    if (!rst_ni) begin
      a_r8_reset_off: assert (coil_o == 4'b0000);
    end
  end
endmodule

bind stepper_seq stepper_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .step_en_i (step_en_i),
  .dir_i     (dir_i),
  .mode_i    (mode_i),
  .ctrl_i    (ctrl_i),
  .phase_i   (phase_q),
  .coil_o    (coil_o)
);

// File: tb/stepper_seq_tb.sv
module stepper_seq_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       step_en_i = 1'b0;
  logic       dir_i = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic [3:0] ctrl_i = 4'd0;
  logic [3:0] coil_o;

  int checks = 0;
  int errors = 0;
  int ph = 0;
  bit done = 1'b0;

  typedef struct {
    logic [3:0] coil;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  logic [3:0] wave_t[4] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000};
  logic [3:0] full_t[4] = '{4'b0011, 4'b0110, 4'b1100, 4'b1001};
  logic [3:0] half_t[8] = '{4'b0001, 4'b0011, 4'b0010, 4'b0110,
                            4'b0100, 4'b1100, 4'b1000, 4'b1001};

  stepper_seq dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_en_i (step_en_i),
    .dir_i     (dir_i),
    .mode_i    (mode_i),
    .ctrl_i    (ctrl_i),
    .coil_o    (coil_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic logic [3:0] model(int m, int p, logic [3:0] c);
    case (m)
      0:       return wave_t[p % 4];
      1:       return full_t[p % 4];
      2:       return half_t[p];
      default: return c;
    endcase
  endfunction

  task automatic check(logic [3:0] act, logic [3:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: coil_o=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(bit en, bit dir, int m, logic [3:0] c, string tag);
    exp_t e;
    @(negedge clk_i);
    step_en_i = en;
    dir_i     = dir;
    mode_i    = m[1:0];
    ctrl_i    = c;
    if (en) ph = dir ? (ph + 1) % 8 : (ph + 7) % 8;
    e.coil = model(m, ph, c);
    e.tag  = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare one expected item per edge, away from the edge
  always @(posedge clk_i) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(coil_o, e.coil, e.tag);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: coil_o=%b expected completion", coil_o);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset clears outputs
    repeat (3) @(negedge clk_i);
    check(coil_o, 4'b0000, "R8 reset");
    rst_ni = 1'b1;

    // R3 / R1: wave upward across the 7->0 wrap
    for (int i = 0; i < 10; i++) drive(1, 1, 0, 4'h0, "R3 wave up R1");
    // R1: wave downward across 0->7
    for (int i = 0; i < 6; i++) drive(1, 0, 0, 4'h0, "R3 wave down R1");
    // R4: full step both ways
    for (int i = 0; i < 9; i++) drive(1, 1, 1, 4'h0, "R4 full up");
    for (int i = 0; i < 9; i++) drive(1, 0, 1, 4'h0, "R4 full down");
    // R5: half step through all eight phases and the wrap
    for (int i = 0; i < 10; i++) drive(1, 1, 2, 4'h0, "R5 half up");
    for (int i = 0; i < 10; i++) drive(1, 0, 2, 4'h0, "R5 half down");
    // R2: idle cycles hold the phase
    for (int i = 0; i < 4; i++) drive(0, i[0], 2, 4'h0, "R2 hold");
    // R6: direct copy while the phase keeps stepping
    drive(1, 1, 3, 4'b1010, "R6 direct");
    drive(1, 1, 3, 4'b0101, "R6 direct");
    drive(0, 1, 3, 4'b1111, "R6 direct");
    drive(1, 1, 3, 4'b0000, "R6 direct");
    drive(1, 0, 3, 4'b1001, "R6 direct");
    drive(1, 1, 3, 4'b0110, "R6 direct");
    drive(0, 1, 2, 4'b1111, "R6 resume half");

    // R7: mode change without a step is not seen before the edge
    drive(0, 1, 1, 4'h0, "R7 mode change after edge");
    @(negedge clk_i);
    mode_i = 2'd0;
    #1;
    check(coil_o, full_t[ph % 4], "R7 before edge");
    @(posedge clk_i);
    #1;
    check(coil_o, wave_t[ph % 4], "R7 after edge");
    // R7: step and mode change at the same edge
    drive(1, 1, 2, 4'h0, "R7 step with mode change");

    repeat (3) @(negedge clk_i);
    check(4'(exp_q.size()), 4'd0, "R7 queue drained");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule